// File: doc/BRIEF.md
# Preloadable Overflow Timer

This block is a free-running up-counter for use as a periodic event source. It can run as an 8-bit or a 16-bit counter. An input tick strobe drives it, and a prescaler can divide that strobe by 1, 2, 4 or 8. Software controls it through a small byte-wide register port. One register holds the mode, the prescale and a run bit. Two registers expose the low and high bytes of the count.

When the count wraps past its top value, the block sets a sticky request flag for an interrupt controller. The counter does not stop there: it wraps and keeps counting. Software chooses the period by preloading the count. For example, a start value of 0xD8F0 in 16-bit mode gives one wrap every 10,000 ticks. In 16-bit mode, a write to the high byte is held aside and is applied together with the next low-byte write, so a preload never leaves a half-updated count behind.

Top module: `ovf_timer`

## Requirements
- R1: Reset (synchronous, active low) clears the count, the control register, the held high byte and the flag, so every register read returns 0x00 and `irq_flag` is 0.
- R2: The register addresses are 0 = control, 1 = count low byte and 2 = count high byte. Address 3 reads as 0x00. In the control byte, bit 7 selects 16-bit mode, bits [5:4] select the prescale (0 = 1:1, 1 = 1:2, 2 = 1:4, 3 = 1:8) and bit 0 is the run bit. All other control bits read back as 0.
- R3: With the run bit set at 1:1 prescale, every cycle with `tick_en` high adds one to the count at the next clock edge. A cycle without `tick_en` leaves the count unchanged.
- R4: At a prescale of 1:2^k, the count advances once for every 2^k accepted ticks.
- R5: In 8-bit mode, the low byte wraps from 0xFF to 0x00 and sets the flag. The high byte keeps its value, and a write to address 2 loads the high byte directly.
- R6: In 16-bit mode, the count wraps from 0xFFFF to 0x0000 and sets the flag. Counting continues after the wrap.
- R7: The flag stays set until `flag_clr` is pulsed. If a wrap and `flag_clr` fall in the same cycle, the flag stays set.
- R8: While the run bit is clear, ticks change neither the count nor the prescaler, and the flag is never set. Setting the run bit again resumes counting from the held value.
- R9: In 16-bit mode, a write to address 2 leaves the count unchanged. The next write to address 1 loads the held high byte and the new low byte together.
- R10: A count write resets the prescaler. A tick in the same cycle as a count write is dropped, and the written value is loaded.
- R11: After a preload of 0xD8F0 in 16-bit mode at 1:1, the flag rises on exactly the 10,000th tick, and the count reads 0x0000 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for both read and write |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| tick_en | input | 1 | Count strobe, one tick per high cycle |
| flag_clr | input | 1 | Clears the overflow request flag |
| irq_flag | output | 1 | Sticky overflow request flag |

## Verification
The assertions check on every cycle the properties that hold at any single edge:
- the count is held when no tick arrives or the timer is stopped;
- a stopped timer never raises the flag;
- the flag stays set until it is cleared;
- the flag rises only together with a low byte of zero;
- a low-byte write always lands;
- a buffered high-byte write leaves the count alone.

The bench scenarios cover the properties that span many cycles: the exact prescale division ratios, the prescaler restart after a preload, the exact 10,000-tick period from 0xD8F0, and the difference between the 8-bit and 16-bit high-byte paths. A reference model run under random register traffic cross-checks the mix of mode changes, preloads and clears.

// File: rtl/tmr_pkg.sv
// Shared definitions for the overflow timer: register addresses,
// control-byte bit positions and the decoded control record.
// Assumes a byte-wide register port of at least 8 bits.
package tmr_pkg;

    localparam int PSC_SEL_W    = 2;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_PSC_LSB = 4;
    localparam int CTRL_WIDE_BIT = 7;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_CNT_LO = 2'd1,
        ADDR_CNT_HI = 2'd2,
        ADDR_UNUSED = 2'd3
    } tmr_addr_e;

    typedef struct packed {
        logic                 wide;
        logic [PSC_SEL_W-1:0] psc_sel;
        logic                 run;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
// Register front end of the overflow timer.
// Holds the control byte and the buffered high byte, forms the
// merged preload value and returns read data combinationally.
// Assumes BYTE_W >= 8 so the control bit positions fit.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = 2 * BYTE_W
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    output tmr_ctrl_t         ctrl_q,
    output logic              ld_en,
    output logic [CNT_W-1:0]  ld_val,
    output logic [BYTE_W-1:0] bus_rdata
);

    logic              wr_ctrl;
    logic              wr_lo;
    logic              wr_hi;
    logic [BYTE_W-1:0] hi_buf_q;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_lo   = bus_wr && (bus_addr == ADDR_CNT_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADDR_CNT_HI);

    // Control register: mode, prescale select and run bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.wide    <= bus_wdata[CTRL_WIDE_BIT];
            ctrl_q.psc_sel <= bus_wdata[CTRL_PSC_LSB +: PSC_SEL_W];
            ctrl_q.run     <= bus_wdata[CTRL_RUN_BIT];
        end
    end

    // High-byte holding register, used only in 16-bit mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_buf_q <= '0;
        end else if (wr_hi && ctrl_q.wide) begin
            hi_buf_q <= bus_wdata;
        end
    end

    // Preload strobe and merged value for the counter lanes.
    always_comb begin
        ld_en  = wr_lo || (wr_hi && !ctrl_q.wide);
        ld_val = cnt_q;
        if (wr_lo) begin
            ld_val[BYTE_W-1:0] = bus_wdata;
            if (ctrl_q.wide) begin
                ld_val[CNT_W-1:BYTE_W] = hi_buf_q;
            end
        end else if (wr_hi) begin
            ld_val[CNT_W-1:BYTE_W] = bus_wdata;
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_WIDE_BIT]                  = ctrl_q.wide;
                bus_rdata[CTRL_PSC_LSB +: PSC_SEL_W]      = ctrl_q.psc_sel;
                bus_rdata[CTRL_RUN_BIT]                   = ctrl_q.run;
            end
            ADDR_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            ADDR_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_prescale.sv
// Tick prescaler: divides accepted ticks by 2^sel.
// Assumes tick_ok is already gated by the run bit and by preloads;
// clr restarts the division phase.
module tmr_prescale #(
    parameter  int SEL_W = 2,
    localparam int DIV_W = (1 << SEL_W) - 1
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_ok,
    input  logic [SEL_W-1:0] sel,
    output logic             adv
);

    logic [DIV_W-1:0] psc_q;
    logic [DIV_W-1:0] mask;

    // Low-bit mask whose all-ones state marks the last tick of a period.
    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    assign adv = tick_ok && ((psc_q & mask) == mask);

    // Phase counter: restarts on preload, steps on each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            psc_q <= '0;
        end else if (tick_ok) begin
            psc_q <= psc_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_count.sv
// Byte-lane counter with mode-dependent wrap detection.
// Lane 0 always counts. Upper lanes only take a carry in wide mode.
// Assumes ld_en and adv are never high together.
module tmr_count #(
    parameter  int BYTE_W = 8,
    parameter  int LANES  = 2,
    localparam int CNT_W  = LANES * BYTE_W
)
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    logic [LANES:0]   carry;
    logic [LANES-1:0] lane_ones;

    assign carry[0] = adv;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        assign lane_ones[g] = &lane_q;
        assign cnt_q[g*BYTE_W +: BYTE_W] = lane_q;

        if (g == LANES - 1) begin : g_top
            assign carry[g+1] = carry[g] && lane_ones[g];
        end else begin : g_mid
            assign carry[g+1] = carry[g] && lane_ones[g] && wide;
        end

        // Lane register: preload wins, otherwise step on incoming carry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (ld_en) begin
                lane_q <= ld_val[g*BYTE_W +: BYTE_W];
            end else if (carry[g]) begin
                lane_q <= lane_q + 1'b1;
            end
        end
    end

    assign ovf = wide ? carry[LANES] : (adv && lane_ones[0]);

endmodule

// File: rtl/tmr_flag.sv
// Sticky request flag: set wins over clear in the same cycle.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Hold the request until an explicit clear without a new set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ovf_timer.sv
// Preloadable 8/16-bit timer with prescaler and sticky overflow flag.
// Assumes a single clock domain. tick_en is a one-cycle strobe per tick.
module ovf_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              flag_clr,
    output logic              irq_flag
);

    localparam int LANES = 2;
    localparam int CNT_W = LANES * BYTE_W;

    tmr_ctrl_t        ctrl_q;
    logic             ld_en;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] cnt_q;
    logic             tick_ok;
    logic             adv;
    logic             ovf;
    logic             run_s;
    logic             wide_s;

    assign run_s   = ctrl_q.run;
    assign wide_s  = ctrl_q.wide;
    assign tick_ok = tick_en && run_s && !ld_en;

    tmr_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .ctrl_q    (ctrl_q),
        .ld_en     (ld_en),
        .ld_val    (ld_val),
        .bus_rdata (bus_rdata)
    );

    tmr_prescale #(.SEL_W(PSC_SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ld_en),
        .tick_ok (tick_ok),
        .sel     (ctrl_q.psc_sel),
        .adv     (adv)
    );

    tmr_count #(.BYTE_W(BYTE_W), .LANES(LANES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wide   (wide_s),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .adv    (adv),
        .cnt_q  (cnt_q),
        .ovf    (ovf)
    );

    tmr_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovf),
        .clr   (flag_clr),
        .flag  (irq_flag)
    );

endmodule

// File: rtl/ovf_timer_chk.sv
// Property checker for ovf_timer, attached through bind.
// Observes ports plus the control, count and preload state.
module ovf_timer_chk #(
    parameter  int BYTE_W = 8,
    localparam int CNT_W  = 2 * BYTE_W
)
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              tick_en,
    input logic              flag_clr,
    input logic              irq_flag,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              wide,
    input logic              ld_en
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !ld_en) |=> $stable(cnt)); // R3

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_en) |=> $stable(cnt)); // R8

    AST_STOPPED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !irq_flag) |=> !irq_flag); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag); // R7

    AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (cnt[BYTE_W-1:0] == '0)); // R5

    AST_LOW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (cnt[BYTE_W-1:0] == $past(bus_wdata))); // R10

    AST_HIGH_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && wide && !tick_en) |=> $stable(cnt)); // R9

endmodule

bind ovf_timer ovf_timer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick_en   (tick_en),
    .flag_clr  (flag_clr),
    .irq_flag  (irq_flag),
    .cnt       (cnt_q),
    .run       (run_s),
    .wide      (wide_s),
    .ld_en     (ld_en)
);

// File: tb/test_ovf_timer.sv
`timescale 1ns/10ps
module test_ovf_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq_flag;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [15:0] m_cnt;
    logic [7:0]  m_buf;
    logic [2:0]  m_psc;
    logic [1:0]  m_sel;
    logic        m_wide, m_run, m_flag;

    always #2.5 clk = ~clk;

    ovf_timer #(.BYTE_W(8)) i_ovf_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .flag_clr  (flag_clr),
        .irq_flag  (irq_flag)
    );

    task automatic model_reset();
        m_cnt = '0; m_buf = '0; m_psc = '0; m_sel = '0;
        m_wide = 1'b0; m_run = 1'b0; m_flag = 1'b0;
    endtask

    function automatic logic [7:0] exp_ctrl();
        return {m_wide, 1'b0, m_sel, 3'b000, m_run};
    endfunction

    task automatic model_step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                              input logic tk, input logic clr);
        logic ld, ok, adv, ovf;
        logic [2:0] mask;
        ld   = wr && (a == 2'd1 || (a == 2'd2 && !m_wide));
        ok   = tk && m_run && !ld;
        mask = 3'((1 << m_sel) - 1);
        adv  = ok && ((m_psc & mask) == mask);
        ovf  = adv && (m_wide ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF));
        if (ld) begin
            if (a == 2'd1) m_cnt = m_wide ? {m_buf, d} : {m_cnt[15:8], d};
            else           m_cnt = {d, m_cnt[7:0]};
            m_psc = '0;
        end else if (ok) begin
            m_psc = m_psc + 3'd1;
            if (adv) m_cnt = m_wide ? m_cnt + 16'd1 : {m_cnt[15:8], m_cnt[7:0] + 8'd1};
        end
        if (wr && a == 2'd2 && m_wide) m_buf = d;
        if (wr && a == 2'd0) begin
            m_wide = d[7]; m_sel = d[5:4]; m_run = d[0];
        end
        if (ovf) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.3;
        v = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] l, h;
        rd(2'd1, l);
        rd(2'd2, h);
        v = {h, l};
    endtask

    task automatic compare_model(input string req);
        logic [7:0]  c;
        logic [15:0] v;
        rd(2'd0, c);
        rd_cnt(v);
        check(req, "ctrl (model)", {8'h00, c}, {8'h00, exp_ctrl()});
        check(req, "count (model)", v, m_cnt);
        check(req, "flag (model)", {15'h0, irq_flag}, {15'h0, m_flag});
    endtask

    task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic tk, input logic clr);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk; flag_clr = clr;
        model_step(wr, a, d, tk, clr);
        @(posedge clk);
        #1;
        bus_wr = 1'b0; tick_en = 1'b0; flag_clr = 1'b0;
        compare_model(cur_req);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic exp_cnt(input string req, input logic [15:0] e);
        logic [15:0] v;
        rd_cnt(v);
        check(req, "count", v, e);
    endtask

    task automatic exp_flag(input string req, input logic e);
        check(req, "flag", {15'h0, irq_flag}, {15'h0, e});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; tick_en = 1'b0; flag_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h00C0FFEE));

        // R1: reset state
        do_reset();
        rd(2'd0, v); check("R1", "ctrl after reset", {8'h0, v}, 16'h0);
        exp_cnt("R1", 16'h0000);
        exp_flag("R1", 1'b0);

        // R2: control encoding and unused address
        cur_req = "R2";
        wr_reg(2'd0, 8'hFF);
        rd(2'd0, v); check("R2", "ctrl readback of 0xFF", {8'h0, v}, 16'h00B1);
        wr_reg(2'd0, 8'h4E);
        rd(2'd0, v); check("R2", "ctrl readback of 0x4E", {8'h0, v}, 16'h0000);
        rd(2'd3, v); check("R2", "unused address", {8'h0, v}, 16'h0000);

        // R3: 1:1 counting and no change without ticks
        cur_req = "R3";
        wr_reg(2'd0, 8'h81);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h10);
        ticks(5);
        exp_cnt("R3", 16'h0015);
        idle(3);
        exp_cnt("R3", 16'h0015);

        // R4: prescale ratios
        cur_req = "R4";
        wr_reg(2'd0, 8'hA1);
        wr_reg(2'd1, 8'h00);
        ticks(8);  exp_cnt("R4", 16'h0002);
        ticks(3);  exp_cnt("R4", 16'h0002);
        wr_reg(2'd0, 8'hB1);
        wr_reg(2'd1, 8'h00);
        ticks(16); exp_cnt("R4", 16'h0002);
        ticks(7);  exp_cnt("R4", 16'h0002);
        ticks(1);  exp_cnt("R4", 16'h0003);

        // R5: 8-bit wrap, high byte kept and written directly
        cur_req = "R5";
        wr_reg(2'd0, 8'h01);
        wr_reg(2'd2, 8'h12);
        wr_reg(2'd1, 8'hFE);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        exp_cnt("R5", 16'h12FE);
        ticks(1); exp_cnt("R5", 16'h12FF); exp_flag("R5", 1'b0);
        ticks(1); exp_cnt("R5", 16'h1200); exp_flag("R5", 1'b1);

        // R7: sticky flag, set beats clear
        cur_req = "R7";
        idle(5);
        exp_flag("R7", 1'b1);
        wr_reg(2'd1, 8'hFF);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b1);
        exp_flag("R7", 1'b1);
        exp_cnt("R7", 16'h1200);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        exp_flag("R7", 1'b0);

        // R6: 16-bit wrap and continuation
        cur_req = "R6";
        wr_reg(2'd0, 8'h81);
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd1, 8'hFE);
        ticks(1); exp_cnt("R6", 16'hFFFF); exp_flag("R6", 1'b0);
        ticks(1); exp_cnt("R6", 16'h0000); exp_flag("R6", 1'b1);
        ticks(1); exp_cnt("R6", 16'h0001);

        // R9: buffered high byte in 16-bit mode
        cur_req = "R9";
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        wr_reg(2'd2, 8'h34);
        exp_cnt("R9", 16'h0001);
        wr_reg(2'd1, 8'h56);
        exp_cnt("R9", 16'h3456);

        // R8: stopped timer holds, then resumes
        cur_req = "R8";
        wr_reg(2'd2, 8'hFF);
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'h80);
        ticks(4);
        exp_cnt("R8", 16'hFFFF); exp_flag("R8", 1'b0);
        wr_reg(2'd0, 8'h81);
        ticks(1);
        exp_cnt("R8", 16'h0000); exp_flag("R8", 1'b1);

        // R10: write beats tick, write restarts prescaler
        cur_req = "R10";
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        cyc(1'b1, 2'd1, 8'h40, 1'b1, 1'b0);
        exp_cnt("R10", 16'hFF40);
        wr_reg(2'd0, 8'h91);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h00);
        ticks(1);
        wr_reg(2'd1, 8'h00);
        ticks(1); exp_cnt("R10", 16'h0000);
        ticks(1); exp_cnt("R10", 16'h0001);

        // R11: 0xD8F0 preload gives a 10,000-tick period
        cur_req = "R11";
        wr_reg(2'd0, 8'h80);
        wr_reg(2'd2, 8'hD8);
        wr_reg(2'd1, 8'hF0);
        wr_reg(2'd0, 8'h81);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        ticks(9999);
        exp_flag("R11", 1'b0); exp_cnt("R11", 16'hFFFF);
        ticks(1);
        exp_flag("R11", 1'b1); exp_cnt("R11", 16'h0000);

        // Random traffic against the reference model (R4 and others)
        cur_req = "R4";
        for (int i = 0; i < 4000; i++) begin
            logic       w, t, c;
            logic [1:0] a;
            logic [7:0] d;
            w = ($urandom % 10) == 0;
            a = 2'($urandom % 3);
            d = 8'($urandom);
            if (a == 2'd0 && ($urandom % 4) != 0) d[0] = 1'b1;
            t = ($urandom % 10) < 7;
            c = ($urandom % 20) == 0;
            cyc(w, a, d, t, c);
        end

        // R1: reset from a busy state
        cur_req = "R1";
        do_reset();
        rd(2'd0, v); check("R1", "ctrl after second reset", {8'h0, v}, 16'h0);
        exp_cnt("R1", 16'h0000);
        exp_flag("R1", 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule